// File: doc/BRIEF.md
# Pattern-Framed Packet Capture Engine

The engine takes the byte stream of one logical channel of a frame-based synchronous ring network and turns it into packets stored in memory. When enabled, it first waits for the first byte of a network frame. It then scans the stream for a programmable 16-bit start pattern. The bytes that follow that pattern are written to memory, one strobe per byte, through a plain address/data/strobe port. The write port has no backpressure.

Two ways to end a packet are selectable. In the first, the packet closes on a 16-bit stop pattern. In the second, one byte at a programmable position inside the packet gives the packet's total length. Packets alternate between two regions of equal size, which gives ping-pong buffering. Each region has its own sticky completion flag, and a separate flag tells which region finished last. If a packet reaches the region size before it ends normally, the engine cuts it off there and records an overflow. The engine keeps hunting for packets until software drops the enable.

Top module: `pfcCaptureTop`

## Requirements
- R1: After reset, `memWrEn`, `doneFlags`, `lastBuf` and `overflow` are all 0.
- R2: After `enable` rises, the engine ignores every byte until it accepts a byte with `frameStart` high. That byte is the first one searched. Nothing before it can match or be written.
- R3: While hunting, no byte is written. The start pattern counts as seen when the two most recently accepted bytes match it, with the earlier byte in bits 15:8. The start-pattern bytes themselves are never written. Capture begins with the next accepted byte.
- R4: With `fixedPattern`=1, a pattern match needs all 16 bits to be equal. With `fixedPattern`=0, only the bit positions where the mask (`startMask` or `stopMask`) holds 1 are compared.
- R5: With `mode`=0, every captured byte is written, including both stop-pattern bytes. The packet ends on the byte that completes a stop-pattern match. Both bytes of that match must belong to the packet.
- R6: With `mode`=1, the captured byte at 0-based index `countPos` holds the length L. The packet ends after max(L, `countPos`+1) bytes.
- R7: Byte n (0-based) of a packet is written at `baseAddr`+n for even-numbered packets and at `baseAddr`+`bufCount`+n for odd-numbered ones. `lastBuf` shows the region (0 or 1) of the latest completed packet.
- R8: When a packet completes in region k, `doneFlags[k]` is set in the same cycle as its last write. The flag stays set until a cycle with `clrDone[k]`=1. A set in the same cycle as a clear wins.
- R9: A packet that reaches `bufCount` bytes without ending normally ends at that byte and sets `overflow`. `overflow` stays set until a cycle with `clrOvf`=1.
- R10: A byte is accepted only in a cycle with `dataValid`=1 and `stall`=0. While stalled, the engine keeps its state and writes nothing.
- R11: Hunting and capturing repeat without limit. Dropping `enable` stops writes from the next cycle on. The next enable restarts at region 0 and waits for a frame start again.
- R12: The write for an accepted byte appears one clock after the byte is accepted, with `memData` equal to that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control |
| mode | input | 1 | 0 = start/stop patterns, 1 = embedded length |
| fixedPattern | input | 1 | 1 = exact compare, 0 = masked compare |
| startPat | input | 16 | Start pattern, earlier byte in bits 15:8 |
| startMask | input | 16 | Compare mask for the start pattern |
| stopPat | input | 16 | Stop pattern |
| stopMask | input | 16 | Compare mask for the stop pattern |
| countPos | input | CNT_W | Index of the length byte in a packet |
| baseAddr | input | ADDR_W | Address of region 0 |
| bufCount | input | CNT_W | Region size in bytes (at least 1) |
| frameStart | input | 1 | Marks the first byte of a network frame |
| dataValid | input | 1 | Byte present on `dataByte` |
| dataByte | input | 8 | Logical-channel byte |
| stall | input | 1 | Hold the engine, no byte accepted |
| clrDone | input | 2 | Write-1-to-clear pulses for `doneFlags` |
| clrOvf | input | 1 | Write-1-to-clear pulse for `overflow` |
| memWrEn | output | 1 | Byte write strobe |
| memAddr | output | ADDR_W | Byte write address |
| memData | output | 8 | Byte write data |
| doneFlags | output | 2 | Sticky completion flag per region |
| lastBuf | output | 1 | Region of the latest completed packet |
| overflow | output | 1 | Sticky truncation flag |

## Verification
The assertions assume a byte is offered only as `dataByte` with `dataValid`. They also assume the clear pulses are the only way software touches the flags, and that configuration inputs stay steady while `enable` is high. The stimulus follows these rules. It changes the pattern, mode and mask settings only between packets, while the engine is hunting, never in the middle of a capture. It holds `bufCount` and `baseAddr` fixed for the whole run. Stall windows keep `dataValid` high with the same byte, the way a real source would hold it.

// File: rtl/pfcPkg.sv
package pfcPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_HUNT,
    ST_CAPT
  } capState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearHist;
    logic shiftHist;
    logic startPkt;
    logic writeByte;
  } dpCtrl_t;
endpackage

// File: rtl/pfcDatapath.sv
module pfcDatapath
  import pfcPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              bufSel,
  input  logic              fixedPattern,
  input  logic [15:0]       startPat,
  input  logic [15:0]       startMask,
  input  logic [15:0]       stopPat,
  input  logic [15:0]       stopMask,
  input  logic [CNT_W-1:0]  countPos,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  bufCount,
  input  logic [7:0]        dataByte,
  output logic              startHit,
  output logic              stopHit,
  output logic              lenHit,
  output logic              capFull,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);
  localparam int CW1 = CNT_W + 1;

  logic [15:0]      hist, nextHist;
  logic [1:0]       histCnt, nextCnt;
  logic [CNT_W-1:0] offset;
  logic [CW1-1:0]   offsetNext;
  logic [7:0]       lenReg;
  logic             lenValid;
  logic             atCountPos;

  function automatic logic patMatch(input logic [15:0] h, input logic [15:0] p,
                                    input logic [15:0] m, input logic exact);
    return exact ? (h == p) : (((h ^ p) & m) == 16'h0);
  endfunction

  always_comb begin
    nextHist   = {hist[7:0], dataByte};
    nextCnt    = (histCnt == 2'd2) ? 2'd2 : histCnt + 2'd1;
    startHit   = (nextCnt == 2'd2) && patMatch(nextHist, startPat, startMask, fixedPattern);
    stopHit    = (nextCnt == 2'd2) && patMatch(nextHist, stopPat, stopMask, fixedPattern);
    offsetNext = CW1'(offset) + CW1'(1);
    atCountPos = (offset == countPos);
    lenHit     = atCountPos ? (CW1'(dataByte) <= offsetNext)
                            : (lenValid && (CW1'(lenReg) <= offsetNext));
    capFull    = (offsetNext == CW1'(bufCount));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist    <= '0;
      histCnt <= '0;
    end else if (ctrl.clearHist) begin
      histCnt <= '0;
    end else if (ctrl.shiftHist) begin
      hist    <= nextHist;
      histCnt <= nextCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offset   <= '0;
      lenReg   <= '0;
      lenValid <= 1'b0;
    end else if (ctrl.startPkt) begin
      offset   <= '0;
      lenValid <= 1'b0;
    end else if (ctrl.writeByte) begin
      offset <= offset + CNT_W'(1);
      if (atCountPos) begin
        lenReg   <= dataByte;
        lenValid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWrEn <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWrEn <= ctrl.writeByte;
      if (ctrl.writeByte) begin
        memAddr <= baseAddr + (bufSel ? ADDR_W'(bufCount) : '0) + ADDR_W'(offset);
        memData <= dataByte;
      end
    end
  end
endmodule

// File: rtl/pfcControl.sv
module pfcControl
  import pfcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       mode,
  input  logic       frameStart,
  input  logic       dataValid,
  input  logic       stall,
  input  logic [1:0] clrDone,
  input  logic       clrOvf,
  input  logic       startHit,
  input  logic       stopHit,
  input  logic       lenHit,
  input  logic       capFull,
  output dpCtrl_t    ctrl,
  output logic       bufSel,
  output logic [1:0] doneFlags,
  output logic       lastBuf,
  output logic       overflow
);
  capState_t state, nextState;
  logic accept, normalEnd, endPkt, finish;
  logic [1:0] doneSet;

  always_comb begin
    accept    = dataValid && !stall;
    normalEnd = mode ? lenHit : stopHit;
    endPkt    = normalEnd || capFull;
    ctrl      = '0;
    nextState = state;
    if (!enable) begin
      nextState      = ST_IDLE;
      ctrl.clearHist = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          ctrl.clearHist = 1'b1;
          nextState      = ST_ALIGN;
        end
        ST_ALIGN: if (accept && frameStart) begin
          ctrl.shiftHist = 1'b1;
          nextState      = ST_HUNT;
        end
        ST_HUNT: if (accept) begin
          ctrl.shiftHist = 1'b1;
          if (startHit) begin
            ctrl.clearHist = 1'b1;
            ctrl.startPkt  = 1'b1;
            nextState      = ST_CAPT;
          end
        end
        ST_CAPT: if (accept) begin
          ctrl.shiftHist = 1'b1;
          ctrl.writeByte = 1'b1;
          if (endPkt) begin
            ctrl.clearHist = 1'b1;
            nextState      = ST_HUNT;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
    finish  = ctrl.writeByte && endPkt;
    doneSet = finish ? (bufSel ? 2'b10 : 2'b01) : 2'b00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bufSel    <= 1'b0;
      doneFlags <= '0;
      lastBuf   <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      state     <= nextState;
      doneFlags <= (doneFlags & ~clrDone) | doneSet;
      overflow  <= (overflow & ~clrOvf) | (finish && !normalEnd);
      if (!enable) bufSel <= 1'b0;
      else if (finish) begin
        bufSel  <= ~bufSel;
        lastBuf <= bufSel;
      end
    end
  end
endmodule

// File: rtl/pfcCaptureTop.sv
module pfcCaptureTop
  import pfcPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              mode,
  input  logic              fixedPattern,
  input  logic [15:0]       startPat,
  input  logic [15:0]       startMask,
  input  logic [15:0]       stopPat,
  input  logic [15:0]       stopMask,
  input  logic [CNT_W-1:0]  countPos,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  bufCount,
  input  logic              frameStart,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  input  logic              stall,
  input  logic [1:0]        clrDone,
  input  logic              clrOvf,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [1:0]        doneFlags,
  output logic              lastBuf,
  output logic              overflow
);
  dpCtrl_t ctrl;
  logic bufSel, startHit, stopHit, lenHit, capFull;

  pfcControl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .frameStart(frameStart), .dataValid(dataValid), .stall(stall),
    .clrDone(clrDone), .clrOvf(clrOvf),
    .startHit(startHit), .stopHit(stopHit), .lenHit(lenHit), .capFull(capFull),
    .ctrl(ctrl), .bufSel(bufSel), .doneFlags(doneFlags),
    .lastBuf(lastBuf), .overflow(overflow)
  );

  pfcDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .bufSel(bufSel),
    .fixedPattern(fixedPattern), .startPat(startPat), .startMask(startMask),
    .stopPat(stopPat), .stopMask(stopMask), .countPos(countPos),
    .baseAddr(baseAddr), .bufCount(bufCount), .dataByte(dataByte),
    .startHit(startHit), .stopHit(stopHit), .lenHit(lenHit), .capFull(capFull),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/pfcCaptureChk.sv
module pfcCaptureChk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       dataValid,
  input logic       stall,
  input logic [7:0] dataByte,
  input logic [1:0] clrDone,
  input logic       clrOvf,
  input logic       memWrEn,
  input logic [7:0] memData,
  input logic [1:0] doneFlags,
  input logic       overflow
);
  assert_write_needs_byte_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(enable && dataValid && !stall));

  assert_stall_blocks_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !memWrEn);

  assert_data_follows_byte_R12: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memData == $past(dataByte)));

  assert_done0_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlags[0] && !clrDone[0]) |=> doneFlags[0]);

  assert_done1_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlags[1] && !clrDone[1]) |=> doneFlags[1]);

  assert_done_with_last_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(doneFlags[0]) || $rose(doneFlags[1])) |-> memWrEn);

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clrOvf) |=> overflow);

  assert_disable_stops_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !memWrEn);
endmodule

bind pfcCaptureTop pfcCaptureChk uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .dataValid(dataValid),
  .stall(stall), .dataByte(dataByte), .clrDone(clrDone), .clrOvf(clrOvf),
  .memWrEn(memWrEn), .memData(memData), .doneFlags(doneFlags),
  .overflow(overflow)
);

// File: tb/pfcCaptureTop_test.sv
`timescale 1ns/1ps
module pfcCaptureTop_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 0, mode = 0, fixedPattern = 1;
  logic [15:0] startPat = 16'hA55A, startMask = 16'hFFFF;
  logic [15:0] stopPat = 16'h0D0A, stopMask = 16'hFFFF;
  logic [7:0] countPos = 8'd1;
  logic [15:0] baseAddr = 16'h0100;
  logic [7:0] bufCount = 8'd8;
  logic frameStart = 0, dataValid = 0, stall = 0, clrOvf = 0;
  logic [7:0] dataByte = 8'h00;
  logic [1:0] clrDone = 2'b00;
  logic memWrEn, lastBuf, overflow;
  logic [15:0] memAddr;
  logic [7:0] memData;
  logic [1:0] doneFlags;

  int tests = 0, fails = 0;
  int wrCount = 0, firstAddr = -1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pfcCaptureTop uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mSt = 0;            // 0 idle, 1 align, 2 hunt, 3 capture
  byte unsigned mQ[$];
  int mN = 0, mLen = 0, mBuf = 0;
  bit mLenKnown = 0;
  bit eWr = 0, eLast = 0, eOvf = 0;
  int eAddr = 0, eData = 0;
  bit [1:0] eDone = 0;

  function automatic bit pm(input int h, input int p, input int m);
    return fixedPattern ? (h == p) : (((h ^ p) & m) == 0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mQ.delete(); mN = 0; mBuf = 0; mLenKnown = 0;
      eWr = 0; eDone = 0; eLast = 0; eOvf = 0;
    end else begin
      bit acc;
      acc = dataValid && !stall;
      eWr = 0;
      eDone = eDone & ~clrDone;
      if (clrOvf) eOvf = 0;
      if (!enable) begin
        mSt = 0; mQ.delete(); mBuf = 0;
      end else begin
        case (mSt)
          0: mSt = 1;
          1: if (acc && frameStart) begin mQ.push_back(dataByte); mSt = 2; end
          2: if (acc) begin
            mQ.push_back(dataByte);
            if (mQ.size() > 2) void'(mQ.pop_front());
            if (mQ.size() == 2 && pm({mQ[0], mQ[1]}, startPat, startMask)) begin
              mQ.delete(); mSt = 3; mN = 0; mLenKnown = 0;
            end
          end
          default: if (acc) begin
            bit stopM, normal, full;
            eWr = 1;
            eAddr = baseAddr + (mBuf ? bufCount : 0) + mN;
            eData = dataByte;
            mQ.push_back(dataByte);
            if (mQ.size() > 2) void'(mQ.pop_front());
            if (mN == countPos) begin mLen = dataByte; mLenKnown = 1; end
            stopM = (mQ.size() == 2) && pm({mQ[0], mQ[1]}, stopPat, stopMask);
            full = (mN + 1 == bufCount);
            normal = mode ? (mLenKnown && mN + 1 >= mLen) : stopM;
            if (normal || full) begin
              eDone[mBuf] = 1; eLast = mBuf[0];
              if (full && !normal) eOvf = 1;
              mBuf ^= 1; mQ.delete(); mSt = 2; mN = 0;
            end else mN++;
          end
        endcase
      end
      #1;
      check("R12 memWrEn", memWrEn, eWr);
      if (eWr && memWrEn) begin
        check("R7 memAddr", memAddr, eAddr);
        check("R12 memData", memData, eData);
      end
      check("R8 doneFlags", doneFlags, eDone);
      check("R7 lastBuf", lastBuf, eLast);
      check("R9 overflow", overflow, eOvf);
      if (memWrEn) begin
        if (wrCount == 0) firstAddr = memAddr;
        wrCount++;
      end
    end
  end

  task automatic sb(input logic [7:0] b, input logic fs = 1'b0);
    dataValid = 1; dataByte = b; frameStart = fs;
    @(negedge clk);
    dataValid = 0; frameStart = 0;
  endtask

  task automatic seg();
    wrCount = 0; firstAddr = -1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int snap;
    repeat (4) @(negedge clk);
    check("R1 memWrEn reset", memWrEn, 0);
    check("R1 doneFlags reset", doneFlags, 0);
    check("R1 overflow reset", overflow, 0);
    check("R1 lastBuf reset", lastBuf, 0);
    rstN = 1;
    @(negedge clk);

    // R2 R3 R5: no frame start yet, then aligned packet closed by stop pattern
    enable = 1; seg();
    @(negedge clk);
    sb(8'hA5); sb(8'h5A); sb(8'h11);
    check("R2 no write before frame start", wrCount, 0);
    sb(8'h00, 1'b1); sb(8'hA5); sb(8'h5A);
    check("R3 no write while hunting", wrCount, 0);
    sb(8'h11); sb(8'h22); sb(8'h0D); sb(8'h0A);
    repeat (2) @(negedge clk);
    check("R5 stop packet length", wrCount, 4);
    check("R5 first address", firstAddr, 16'h0100);
    check("R8 done0 set", doneFlags, 2'b01);

    // R7: second packet to region 1
    seg();
    sb(8'hA5); sb(8'h5A); sb(8'h33); sb(8'h0D); sb(8'h0A);
    repeat (2) @(negedge clk);
    check("R7 region1 count", wrCount, 3);
    check("R7 region1 address", firstAddr, 16'h0108);
    check("R7 lastBuf region1", lastBuf, 1);
    clrDone = 2'b11; @(negedge clk); clrDone = 2'b00; @(negedge clk);
    check("R8 flags cleared", doneFlags, 0);

    // R9: overflow truncates at bufCount
    seg();
    sb(8'hA5); sb(8'h5A);
    for (int i = 1; i <= 10; i++) sb(8'(i));
    repeat (2) @(negedge clk);
    check("R9 truncated length", wrCount, 8);
    check("R9 overflow set", overflow, 1);
    clrOvf = 1; @(negedge clk); clrOvf = 0; @(negedge clk);
    check("R9 overflow cleared", overflow, 0);

    // R4: exact vs masked start compare
    startPat = 16'hA500; startMask = 16'hFF00; seg();
    sb(8'hA5); sb(8'h77); sb(8'h42);
    repeat (2) @(negedge clk);
    check("R4 exact compare rejects", wrCount, 0);
    fixedPattern = 0;
    sb(8'hA5); sb(8'h77); sb(8'h0D); sb(8'h0A);
    repeat (2) @(negedge clk);
    check("R4 masked compare accepts", wrCount, 2);
    check("R4 region1 address", firstAddr, 16'h0108);
    fixedPattern = 1; startPat = 16'hA55A; startMask = 16'hFFFF;

    // R6: embedded length mode
    mode = 1; seg();
    sb(8'hA5); sb(8'h5A); sb(8'h01); sb(8'h05); sb(8'h02); sb(8'h03); sb(8'h04);
    repeat (2) @(negedge clk);
    check("R6 length five", wrCount, 5);
    seg();
    sb(8'hA5); sb(8'h5A); sb(8'h09); sb(8'h01);
    repeat (2) @(negedge clk);
    check("R6 short length ends at count byte", wrCount, 2);
    check("R6 region1 address", firstAddr, 16'h0108);
    mode = 0;

    // R10: stall holds the engine
    seg();
    sb(8'hA5); sb(8'h5A); sb(8'h11);
    @(negedge clk);
    snap = wrCount;
    stall = 1; dataValid = 1; dataByte = 8'h22;
    repeat (3) @(negedge clk);
    check("R10 no write during stall", wrCount, snap);
    stall = 0; dataValid = 0;
    sb(8'h22); sb(8'h0D); sb(8'h0A);
    repeat (2) @(negedge clk);
    check("R10 packet intact after stall", wrCount, 4);

    // R11: disable and re-enable restarts at region 0, waits for frame
    enable = 0; repeat (2) @(negedge clk);
    enable = 1; seg(); @(negedge clk);
    sb(8'hA5); sb(8'h5A); sb(8'h11); sb(8'h0D); sb(8'h0A);
    repeat (2) @(negedge clk);
    check("R11 waits for frame after re-enable", wrCount, 0);
    sb(8'h00, 1'b1); sb(8'hA5); sb(8'h5A); sb(8'h55); sb(8'h0D); sb(8'h0A);
    repeat (2) @(negedge clk);
    check("R11 count after restart", wrCount, 3);
    check("R11 restart in region 0", firstAddr, 16'h0100);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule